// File: doc/BRIEF.md
# Idle-Port Store Verify Scheduler

This block sits beside a core's load/store pipeline and checks, without ever delaying real memory traffic, whether a pending store would write the value already held in the data cache. It keeps a small in-order ring of stores waiting to commit, each with an address, data and a verify state. In every cycle each of the two cache read ports is either claimed by a ready load or store (the `port_busy` input) or left idle. Each idle port is handed to the oldest store that has not yet started a verify. The read address and a tag go out on the port at once.

One cycle after issue, the cache returns the word for that tag together with a hit flag. On a hit, the block compares the word with the store's data and records whether the store is silent. A miss, or a different value, leaves the store non-silent. At commit, the store at the head of the ring shows one bit that says whether it must be written. Silent stores are suppressed and counted. A store that reaches commit before its result has come back is simply written. Commit never waits for a verify, and a result that comes back after its store has left is thrown away.

Top module: `ssv_sched`

## Requirements
- R1: After reset the ring is empty: `head_vld`=0, `tbl_full`=0, `sq_cnt`=0, and no verify is issued even when both ports are idle.
- R2: A verify is never issued on a port whose `port_busy` bit is 1 in that cycle.
- R3: Stores waiting for a verify are served oldest first. Idle ports are filled in index order, so port 0 (if idle) gets the oldest waiting store and the next idle port gets the next one. Up to two verifies start in one cycle, in the same cycle the ports are seen idle, with `vfy_addr` equal to the store's address.
- R4: A store is sent for verification at most once, whether its result is still outstanding or already recorded.
- R5: A response arrives one cycle after issue, with the issued tag echoed on `rsp_tag`. On a hit with read data equal to the store data, the store is silent. At commit it then shows `head_wr`=0, which means the write is suppressed.
- R6: A response that misses (`rsp_hit`=0), or that returns data different from the store data, leaves the store non-silent (`head_wr`=1).
- R7: A store committed before its verify result is recorded shows `head_wr`=1. A result that comes back after that store has committed changes no state and no count.
- R8: `sq_cnt` rises by one for each commit with `head_wr`=0 and otherwise holds. It wraps modulo 2^CNT_W.
- R9: Stores commit in the order they were allocated, with `head_addr`/`head_data` showing the oldest store. `tbl_full` is 1 exactly when DEPTH stores are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_vld | input | 1 | Enter a store at the tail of the ring (keep low while `tbl_full`) |
| alloc_addr | input | ADDR_W | Address of the entering store |
| alloc_data | input | DATA_W | Data of the entering store |
| tbl_full | output | 1 | All DEPTH ring entries hold pending stores |
| port_busy | input | 2 | Per-port: a ready load or store holds this port this cycle |
| vfy_vld | output | 2 | Per-port: verify read issued this cycle |
| vfy_addr | output | 2*ADDR_W | Per-port verify address, port p at bits p*ADDR_W upward |
| vfy_tag | output | 2*TAG_W | Per-port verify tag, to be echoed with the response |
| rsp_vld | input | 2 | Per-port: verify response present |
| rsp_hit | input | 2 | Per-port: response came from a cache hit |
| rsp_tag | input | 2*TAG_W | Per-port echoed tag |
| rsp_data | input | 2*DATA_W | Per-port cache word read |
| cmt_stb | input | 1 | Commit the head store this cycle (ignored when `head_vld`=0) |
| head_vld | output | 1 | Ring holds at least one store |
| head_addr | output | ADDR_W | Address of the oldest store |
| head_data | output | DATA_W | Data of the oldest store |
| head_wr | output | 1 | 1: write the head store; 0: suppress it as silent |
| sq_cnt | output | CNT_W | Number of suppressed commits, wrapping |

## Verification
The hardest case to reach is a verify whose result races the commit of its own store. The verify is issued in the very cycle that the store leaves the ring, and the response comes back to an entry that is already free. The bench sets this up with a single silent store: it frees both ports and raises the commit strobe in the same cycle. It then checks that the store was written and that the late response leaves the count alone. The remaining stimulus sweeps every busy-port pattern against every mix of silent, changed and missing stores, for every ring fill level. The oldest-first port assignment and the per-store write bit can then be predicted by simple counting.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
  localparam int NPORT = 2;

  typedef enum logic [1:0] {
    VS_IDLE = 2'd0,
    VS_PEND = 2'd1,
    VS_DONE = 2'd2
  } vst_e;
endpackage

// File: rtl/ssv_pick.sv
module ssv_pick #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0]                          head_idx,
  input  logic [DEPTH-1:0]                          elig,
  input  logic [ssv_pkg::NPORT-1:0]                 port_busy,
  output logic [ssv_pkg::NPORT-1:0]                 pick_vld,
  output logic [ssv_pkg::NPORT-1:0][IDX_W-1:0]      pick_idx
);
  logic [DEPTH-1:0] taken;
  logic [IDX_W-1:0] ix;

  // Each idle port, lowest index first, scans the ring from the head.
  always_comb begin
    taken    = '0;
    pick_vld = '0;
    pick_idx = '0;
    ix       = '0;
    for (int p = 0; p < ssv_pkg::NPORT; p++) begin
      if (!port_busy[p]) begin
        for (int k = 0; k < DEPTH; k++) begin
          ix = head_idx + IDX_W'(k);
          if (!pick_vld[p] && elig[ix] && !taken[ix]) begin
            pick_vld[p] = 1'b1;
            pick_idx[p] = ix;
            taken[ix]   = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ssv_rsp.sv
module ssv_rsp #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                         rsp_vld,
  input  logic                         rsp_hit,
  input  logic [IDX_W:0]               rsp_tag,
  input  logic [DATA_W-1:0]            rsp_data,
  input  logic [DEPTH-1:0]             ent_vld,
  input  logic [DEPTH-1:0]             ent_gen,
  input  logic [DEPTH-1:0]             ent_pend,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  output logic                         upd,
  output logic [IDX_W-1:0]             upd_idx,
  output logic                         upd_sil
);
  logic tag_gen;

  assign upd_idx = rsp_tag[IDX_W-1:0];
  assign tag_gen = rsp_tag[IDX_W];

  // Drop responses for freed, reused or not-outstanding entries.
  assign upd     = rsp_vld && ent_vld[upd_idx] && ent_pend[upd_idx] &&
                   (ent_gen[upd_idx] == tag_gen);
  assign upd_sil = rsp_hit && (rsp_data == ent_data[upd_idx]);
endmodule

// File: rtl/ssv_sqcnt.sv
module ssv_sqcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (inc) cnt_n = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt_n;
  end
endmodule

// File: rtl/ssv_sched.sv
module ssv_sched #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = IDX_W + 1,
  localparam int NP    = ssv_pkg::NPORT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_vld,
  input  logic [ADDR_W-1:0]  alloc_addr,
  input  logic [DATA_W-1:0]  alloc_data,
  output logic               tbl_full,
  input  logic [NP-1:0]      port_busy,
  output logic [NP-1:0]      vfy_vld,
  output logic [NP*ADDR_W-1:0] vfy_addr,
  output logic [NP*TAG_W-1:0]  vfy_tag,
  input  logic [NP-1:0]      rsp_vld,
  input  logic [NP-1:0]      rsp_hit,
  input  logic [NP*TAG_W-1:0]  rsp_tag,
  input  logic [NP*DATA_W-1:0] rsp_data,
  input  logic               cmt_stb,
  output logic               head_vld,
  output logic [ADDR_W-1:0]  head_addr,
  output logic [DATA_W-1:0]  head_data,
  output logic               head_wr,
  output logic [CNT_W-1:0]   sq_cnt
);
  import ssv_pkg::*;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  // ring state
  logic [DEPTH-1:0]             ent_vld, ent_vld_n;
  logic [DEPTH-1:0]             ent_gen, ent_gen_n;
  logic [DEPTH-1:0]             ent_sil, ent_sil_n;
  vst_e                         ent_st   [DEPTH];
  vst_e                         ent_st_n [DEPTH];
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [IDX_W-1:0]             head, head_n, tail, tail_n;
  logic [IDX_W:0]               occ, occ_n;

  logic [DEPTH-1:0] elig, pend;
  logic             do_alloc, do_cmt;

  logic [NP-1:0]            pick_vld;
  logic [NP-1:0][IDX_W-1:0] pick_idx;
  logic [NP-1:0]            upd, upd_sil;
  logic [NP-1:0][IDX_W-1:0] upd_idx;

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      elig[e] = ent_vld[e] && (ent_st[e] == VS_IDLE);
      pend[e] = ent_st[e] == VS_PEND;
    end
  end

  assign tbl_full = occ == (IDX_W+1)'(DEPTH);
  assign head_vld = ent_vld[head];
  assign head_addr = ent_addr[head];
  assign head_data = ent_data[head];
  assign head_wr  = !((ent_st[head] == VS_DONE) && ent_sil[head]);
  assign do_alloc = alloc_vld && !tbl_full;
  assign do_cmt   = cmt_stb && head_vld;

  ssv_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .head_idx (head),
    .elig     (elig),
    .port_busy(port_busy),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign vfy_vld[p]                  = pick_vld[p];
    assign vfy_addr[p*ADDR_W +: ADDR_W] = ent_addr[pick_idx[p]];
    assign vfy_tag[p*TAG_W +: TAG_W]    = {ent_gen[pick_idx[p]], pick_idx[p]};

    ssv_rsp #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rsp (
      .rsp_vld (rsp_vld[p]),
      .rsp_hit (rsp_hit[p]),
      .rsp_tag (rsp_tag[p*TAG_W +: TAG_W]),
      .rsp_data(rsp_data[p*DATA_W +: DATA_W]),
      .ent_vld (ent_vld),
      .ent_gen (ent_gen),
      .ent_pend(pend),
      .ent_data(ent_data),
      .upd     (upd[p]),
      .upd_idx (upd_idx[p]),
      .upd_sil (upd_sil[p])
    );
  end

  // next state: issue, then results, then commit, then allocation
  always_comb begin
    ent_vld_n = ent_vld;
    ent_gen_n = ent_gen;
    ent_sil_n = ent_sil;
    for (int e = 0; e < DEPTH; e++) ent_st_n[e] = ent_st[e];
    head_n = head;
    tail_n = tail;
    occ_n  = occ;
    for (int p = 0; p < NP; p++) begin
      if (pick_vld[p]) ent_st_n[pick_idx[p]] = VS_PEND;
    end
    for (int p = 0; p < NP; p++) begin
      if (upd[p]) begin
        ent_st_n[upd_idx[p]]  = VS_DONE;
        ent_sil_n[upd_idx[p]] = upd_sil[p];
      end
    end
    if (do_cmt) begin
      ent_vld_n[head] = 1'b0;
      head_n          = head + IDX_W'(1);
    end
    if (do_alloc) begin
      ent_vld_n[tail] = 1'b1;
      ent_gen_n[tail] = ~ent_gen[tail];
      ent_sil_n[tail] = 1'b0;
      ent_st_n[tail]  = VS_IDLE;
      tail_n          = tail + IDX_W'(1);
    end
    occ_n = occ + (IDX_W+1)'(do_alloc) - (IDX_W+1)'(do_cmt);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ent_vld <= '0;
      ent_gen <= '0;
      ent_sil <= '0;
      for (int e = 0; e < DEPTH; e++) ent_st[e] <= VS_IDLE;
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      ent_vld <= ent_vld_n;
      ent_gen <= ent_gen_n;
      ent_sil <= ent_sil_n;
      for (int e = 0; e < DEPTH; e++) ent_st[e] <= ent_st_n[e];
      head <= head_n;
      tail <= tail_n;
      occ  <= occ_n;
    end
  end

  // payload storage, no reset, written on allocation only
  always_ff @(posedge clk) begin
    if (do_alloc) begin
      ent_addr[tail] <= alloc_addr;
      ent_data[tail] <= alloc_data;
    end
  end

  ssv_sqcnt #(.CNT_W(CNT_W)) u_sqcnt (
    .clk  (clk),
    .rst_n(rst_i_n),
    .inc  (do_cmt && !head_wr),
    .cnt  (sq_cnt)
  );
endmodule

// File: rtl/ssv_sched_chk.sv
module ssv_sched_chk #(
  parameter int TAG_W = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       port_busy,
  input logic [1:0]       vfy_vld,
  input logic [2*TAG_W-1:0] vfy_tag,
  input logic             cmt_stb,
  input logic             head_vld,
  input logic             head_wr,
  input logic             tbl_full,
  input logic [CNT_W-1:0] sq_cnt
);
  // R2: a busy port never carries a verify
  a_r2_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_vld & port_busy) == 2'b00);

  // R3: port 1 is used only after an idle port 0 is already used
  a_r3_low_port_first: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_vld[1] && !port_busy[0]) |-> vfy_vld[0]);

  // R4: two verifies in one cycle go to different stores
  a_r4_distinct_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_vld == 2'b11) |-> (vfy_tag[TAG_W-1:0] != vfy_tag[2*TAG_W-1:TAG_W]));

  // R8: counter steps only on a suppressed commit
  a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sq_cnt == $past(sq_cnt) + CNT_W'($past(cmt_stb && head_vld && !head_wr)));

  // R9: a full ring stays full until something commits
  a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_full && !cmt_stb) |=> tbl_full);

  // R1: an empty ring is never reported full
  a_r1_empty_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    !head_vld |-> !tbl_full);
endmodule

bind ssv_sched ssv_sched_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .port_busy(port_busy),
  .vfy_vld  (vfy_vld),
  .vfy_tag  (vfy_tag),
  .cmt_stb  (cmt_stb),
  .head_vld (head_vld),
  .head_wr  (head_wr),
  .tbl_full (tbl_full),
  .sq_cnt   (sq_cnt)
);

// File: tb/test_ssv_sched.sv
module test_ssv_sched;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 3;
  localparam int CW = 4;

  logic          clk, rst_n;
  logic          alloc_vld;
  logic [AW-1:0] alloc_addr;
  logic [DW-1:0] alloc_data;
  logic          tbl_full;
  logic [1:0]    port_busy, vfy_vld, rsp_vld, rsp_hit;
  logic [2*AW-1:0] vfy_addr;
  logic [2*TW-1:0] vfy_tag, rsp_tag;
  logic [2*DW-1:0] rsp_data;
  logic          cmt_stb, head_vld, head_wr;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [CW-1:0] sq_cnt;

  ssv_sched #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .CNT_W(CW)) i_ssv_sched (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_addr(alloc_addr),
    .alloc_data(alloc_data), .tbl_full(tbl_full), .port_busy(port_busy),
    .vfy_vld(vfy_vld), .vfy_addr(vfy_addr), .vfy_tag(vfy_tag),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .cmt_stb(cmt_stb), .head_vld(head_vld), .head_addr(head_addr),
    .head_data(head_data), .head_wr(head_wr), .sq_cnt(sq_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  int  exp_sq = 0;
  bit  done = 1'b0;

  logic [1:0]      pv_vld;
  logic [2*AW-1:0] pv_addr;
  logic [2*TW-1:0] pv_tag;

  // cache model: word value from address, hit below 0x0100
  function automatic logic [DW-1:0] cval(input logic [AW-1:0] a);
    return {a ^ 16'h5AC3, a + 16'h1234};
  endfunction
  function automatic logic chit(input logic [AW-1:0] a);
    return a < 16'h0100;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // one cycle: respond to last cycle's verifies, set inputs, settle, capture
  task automatic drive(input logic [1:0] b, input logic av, input logic [AW-1:0] aa,
                       input logic [DW-1:0] ad, input logic c);
    @(negedge clk);
    rsp_vld = pv_vld;
    rsp_tag = pv_tag;
    for (int p = 0; p < 2; p++) begin
      rsp_data[p*DW +: DW] = cval(pv_addr[p*AW +: AW]);
      rsp_hit[p]           = chit(pv_addr[p*AW +: AW]);
    end
    port_busy  = b;
    alloc_vld  = av;
    alloc_addr = aa;
    alloc_data = ad;
    cmt_stb    = c;
    #1;
    pv_vld  = vfy_vld;
    pv_addr = vfy_addr;
    pv_tag  = vfy_tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [AW-1:0] sa [4];
  logic [DW-1:0] sd [4];
  bit            sx [4];

  initial begin
    rst_n = 1'b0; alloc_vld = 1'b0; alloc_addr = '0; alloc_data = '0;
    port_busy = 2'b11; cmt_stb = 1'b0; rsp_vld = '0; rsp_hit = '0;
    rsp_tag = '0; rsp_data = '0; pv_vld = '0; pv_addr = '0; pv_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: empty after reset, idle ports issue nothing
    drive(2'b00, 1'b0, '0, '0, 1'b0);
    chk(head_vld == 1'b0, "R1 head_vld", 64'(head_vld), 64'd0);
    chk(tbl_full == 1'b0, "R1 tbl_full", 64'(tbl_full), 64'd0);
    chk(vfy_vld == 2'b00, "R1 vfy_vld", 64'(vfy_vld), 64'd0);
    chk(sq_cnt == '0, "R1 sq_cnt", 64'(sq_cnt), 64'd0);

    // sweep: fill level x busy pattern x silent mask x miss mask
    for (int n = 1; n <= 4; n++) begin
      for (int b = 0; b < 4; b++) begin
        for (int sm = 0; sm < (1 << n); sm++) begin
          for (int mm = 0; mm < (1 << n); mm++) begin
            int nv;
            for (int i = 0; i < n; i++) begin
              sa[i] = AW'(i + 16 * b) | (mm[i] ? 16'h0100 : 16'h0000);
              sd[i] = cval(sa[i]) ^ (sm[i] ? 32'h0 : 32'h0000_0100);
              drive(2'b11, 1'b1, sa[i], sd[i], 1'b0);
              chk(vfy_vld == 2'b00, "R2 busy fill", 64'(vfy_vld), 64'd0);
            end
            drive(2'(b), 1'b0, '0, '0, 1'b0);
            chk(tbl_full == (n == 4), "R9 tbl_full", 64'(tbl_full), 64'(n == 4));
            nv = 0;
            for (int p = 0; p < 2; p++) begin
              bit ev;
              ev = !b[p] && (nv < n);
              chk(vfy_vld[p] == ev, "R2/R3 port issue", 64'(vfy_vld[p]), 64'(ev));
              if (ev) begin
                chk(vfy_addr[p*AW +: AW] == sa[nv], "R3 oldest first",
                    64'(vfy_addr[p*AW +: AW]), 64'(sa[nv]));
                nv++;
              end
            end
            drive(2'b11, 1'b0, '0, '0, 1'b0);
            for (int i = 0; i < n; i++) begin
              bit ew;
              ew = !((i < nv) && sm[i] && !mm[i]);
              drive(2'b11, 1'b0, '0, '0, 1'b1);
              chk(head_vld && head_addr == sa[i] && head_data == sd[i], "R9 head order",
                  64'(head_addr), 64'(sa[i]));
              chk(head_wr == ew, ew ? "R6 write bit" : "R5 suppress bit",
                  64'(head_wr), 64'(ew));
              if (!ew) exp_sq++;
            end
            drive(2'b11, 1'b0, '0, '0, 1'b0);
            chk(sq_cnt == CW'(exp_sq), "R8 sq_cnt", 64'(sq_cnt), 64'(CW'(exp_sq)));
          end
        end
      end
    end

    // R4: two silent stores, ports idle for three cycles, issued once only
    sa[0] = 16'h0021; sa[1] = 16'h0022;
    drive(2'b11, 1'b1, sa[0], cval(sa[0]), 1'b0);
    drive(2'b11, 1'b1, sa[1], cval(sa[1]), 1'b0);
    drive(2'b00, 1'b0, '0, '0, 1'b0);
    chk(vfy_vld == 2'b11, "R3 dual issue", 64'(vfy_vld), 64'd3);
    drive(2'b00, 1'b0, '0, '0, 1'b0);
    chk(vfy_vld == 2'b00, "R4 no reissue pending", 64'(vfy_vld), 64'd0);
    drive(2'b00, 1'b0, '0, '0, 1'b0);
    chk(vfy_vld == 2'b00, "R4 no reissue done", 64'(vfy_vld), 64'd0);
    for (int i = 0; i < 2; i++) begin
      drive(2'b11, 1'b0, '0, '0, 1'b1);
      chk(head_wr == 1'b0, "R5 silent after idle", 64'(head_wr), 64'd0);
      exp_sq++;
    end
    drive(2'b11, 1'b0, '0, '0, 1'b0);
    chk(sq_cnt == CW'(exp_sq), "R8 sq_cnt directed", 64'(sq_cnt), 64'(CW'(exp_sq)));

    // R7: verify issued in the commit cycle; late result must be dropped
    sa[0] = 16'h0030;
    drive(2'b11, 1'b1, sa[0], cval(sa[0]), 1'b0);
    drive(2'b00, 1'b0, '0, '0, 1'b1);
    chk(vfy_vld[0] == 1'b1, "R7 race issue", 64'(vfy_vld[0]), 64'd1);
    chk(head_wr == 1'b1, "R7 unverified written", 64'(head_wr), 64'd1);
    drive(2'b11, 1'b0, '0, '0, 1'b0);
    chk(head_vld == 1'b0, "R7 ring empty", 64'(head_vld), 64'd0);
    drive(2'b11, 1'b0, '0, '0, 1'b0);
    chk(sq_cnt == CW'(exp_sq), "R7 count unchanged", 64'(sq_cnt), 64'(CW'(exp_sq)));
    sa[1] = 16'h0031;
    drive(2'b11, 1'b1, sa[1], cval(sa[1]), 1'b0);
    drive(2'b11, 1'b0, '0, '0, 1'b1);
    chk(head_wr == 1'b1, "R7 never verified", 64'(head_wr), 64'd1);
    drive(2'b11, 1'b0, '0, '0, 1'b0);
    chk(sq_cnt == CW'(exp_sq), "R8 no count on write", 64'(sq_cnt), 64'(CW'(exp_sq)));

    finish_run();
  end
endmodule